// File: doc/BRIEF.md
# Round-Trip Latency Probe

This block measures the delay of a stream link in clock cycles. It has two halves. The initiator sends a single test word on command and starts counting cycles. The count stops when the reply word comes back. The responder sits at the far end of the link and returns one word for every word it takes in. The returned word is the incoming word with its least significant bit flipped, so the initiator can tell a real answer from a stale or looped-back word.

Every stream uses a valid/ready handshake: a word moves on a rising clock edge at which both valid and ready are high. The measured count, a done indication, a timeout flag and a reply-match flag stay on the outputs until the next measurement starts, so a host processor can read them at any time afterwards. The link itself and any clock-domain crossing sit outside the block. The default counter width reaches far beyond the round trip of about 600 cycles expected on a board-to-board link.

Top module: `rtt_probe`

## Requirements
- R1: While reset is held and after it is released, `ini_tx_valid`, `ini_rx_ready`, `rsp_tx_valid`, `busy`, `done`, `timed_out` and `reply_ok` are 0, `rtt_count` is 0 and `rsp_rx_ready` is 1.
- R2: A `start` pulse seen while the probe is idle or done captures `ping_word`. The probe then drives that word on `ini_tx_data` with `ini_tx_valid` high until one handshake on the initiator transmit stream. Exactly one word is sent per measurement.
- R3: A `start` that arrives while a measurement is running (`busy` high) has no effect. No second word is sent, and the word being sent or already sent is not replaced.
- R4: `rtt_count` equals the number of clock edges from the edge of the send handshake to the edge of the reply handshake. The edge that follows the send handshake counts as 1, and the reply edge is included.
- R5: `ini_rx_ready` is high only while the probe waits for the reply. Accepting the reply ends the measurement, and `done` goes high on the next cycle.
- R6: `reply_ok` is set when the accepted reply equals the sent word with bit 0 inverted. Any other value clears it, and the measurement still ends.
- R7: With no reply, the probe ends after TIMEOUT counted cycles with `timed_out`=1 and `rtt_count`=TIMEOUT. A reply accepted on the last counted cycle takes priority over the timeout.
- R8: The responder emits exactly one word for each word it accepts, in arrival order, equal to the accepted word with bit 0 inverted. The word and its valid stay stable while `rsp_tx_ready` is low.
- R9: `rsp_rx_ready` is high when the responder holds no word, or when its held word leaves on the same edge.
- R10: After a measurement ends, `rtt_count` and the flags hold their values until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a measurement |
| ping_word | input | W | Word to send |
| ini_tx_valid | output | 1 | Initiator outgoing word valid |
| ini_tx_ready | input | 1 | Link accepts the outgoing word |
| ini_tx_data | output | W | Initiator outgoing word |
| ini_rx_valid | input | 1 | Reply word valid |
| ini_rx_ready | output | 1 | Initiator accepts the reply |
| ini_rx_data | input | W | Reply word |
| rsp_rx_valid | input | 1 | Responder incoming word valid |
| rsp_rx_ready | output | 1 | Responder accepts an incoming word |
| rsp_rx_data | input | W | Responder incoming word |
| rsp_tx_valid | output | 1 | Responder echo valid |
| rsp_tx_ready | input | 1 | Link accepts the echo |
| rsp_tx_data | output | W | Echo word |
| busy | output | 1 | Sending or waiting |
| done | output | 1 | Measurement finished, results valid |
| timed_out | output | 1 | Last measurement hit the limit |
| reply_ok | output | 1 | Last reply matched the expected echo |
| rtt_count | output | CW | Measured round trip in cycles |

## Verification
The embedded assertions check on every cycle the properties that one or two cycles of history can show. Words held under backpressure stay stable on both transmit streams. Each responder accept produces the inverted-bit echo on the next cycle. Accepting a reply leads to done. A rising timeout flag comes with a count equal to the limit. Results hold while done and no start arrives. Only the bench's scenarios can show the end-to-end figures: that the count matches the exact reply delay, including a round trip near 600 cycles, that a start during a run is ignored, that a wrong reply clears the match flag, that a reply on the last counted cycle beats the timeout, and that echo order holds under mixed backpressure.

// File: rtl/rtt_probe.sv
module rtt_probe #(
  parameter int W       = 32,
  parameter int CW      = 16,
  parameter int TIMEOUT = 4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  ping_word,
  output logic          ini_tx_valid,
  input  logic          ini_tx_ready,
  output logic [W-1:0]  ini_tx_data,
  input  logic          ini_rx_valid,
  output logic          ini_rx_ready,
  input  logic [W-1:0]  ini_rx_data,
  input  logic          rsp_rx_valid,
  output logic          rsp_rx_ready,
  input  logic [W-1:0]  rsp_rx_data,
  output logic          rsp_tx_valid,
  input  logic          rsp_tx_ready,
  output logic [W-1:0]  rsp_tx_data,
  output logic          busy,
  output logic          done,
  output logic          timed_out,
  output logic          reply_ok,
  output logic [CW-1:0] rtt_count
);

  localparam logic [W-1:0]  FLIP = W'(1);
  localparam logic [CW-1:0] LIM  = CW'(TIMEOUT);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_DONE} st_t;

  st_t           st;
  logic [W-1:0]  ping;
  logic [CW-1:0] cnt;
  logic          to_q, ok_q;
  logic          hold_v;
  logic [W-1:0]  hold_d;

  wire           can_start = start && (st == S_IDLE || st == S_DONE);
  wire [CW-1:0]  cnt_nx    = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ping <= '0;
      cnt  <= '0;
      to_q <= 1'b0;
      ok_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (can_start) begin
          st   <= S_SEND;
          ping <= ping_word;
          cnt  <= '0;
          to_q <= 1'b0;
          ok_q <= 1'b0;
        end
        S_SEND: if (ini_tx_ready) st <= S_WAIT;
        S_WAIT: begin
          cnt <= cnt_nx;
          if (ini_rx_valid) begin
            st   <= S_DONE;
            ok_q <= (ini_rx_data == (ping ^ FLIP));
          end else if (cnt_nx >= LIM) begin
            st   <= S_DONE;
            to_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ini_tx_valid = (st == S_SEND);
  assign ini_tx_data  = ping;
  assign ini_rx_ready = (st == S_WAIT);
  assign busy         = (st == S_SEND) || (st == S_WAIT);
  assign done         = (st == S_DONE);
  assign timed_out    = to_q;
  assign reply_ok     = ok_q;
  assign rtt_count    = cnt;

  assign rsp_rx_ready = !hold_v || rsp_tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (rsp_rx_valid && rsp_rx_ready) begin
      hold_v <= 1'b1;
      hold_d <= rsp_rx_data ^ FLIP;
    end else if (rsp_tx_ready) begin
      hold_v <= 1'b0;
    end
  end

  assign rsp_tx_valid = hold_v;
  assign rsp_tx_data  = hold_d;

  a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_tx_valid && !ini_tx_ready) |=> (ini_tx_valid && $stable(ini_tx_data)));

  a_r5_reply_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_rx_valid && ini_rx_ready) |=> (done && !ini_rx_ready));

  a_r7_timeout_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> (done && rtt_count == LIM));

  a_r8_echo_value: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rx_valid && rsp_rx_ready) |=> (rsp_tx_valid && rsp_tx_data == ($past(rsp_rx_data) ^ FLIP)));

  a_r8_echo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_tx_valid && !rsp_tx_ready) |=> (rsp_tx_valid && $stable(rsp_tx_data)));

  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(rtt_count) && $stable(timed_out) && $stable(reply_ok)));

endmodule

// File: tb/rtt_probe_tb.sv
module rtt_probe_tb_top;
  localparam int CLK_PERIOD = 8;
  localparam int W  = 32;
  localparam int CW = 16;
  localparam int TO = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] ping_word = '0;
  logic ini_tx_valid, ini_tx_ready = 1'b0;
  logic [W-1:0] ini_tx_data;
  logic ini_rx_valid = 1'b0, ini_rx_ready;
  logic [W-1:0] ini_rx_data = '0;
  logic rsp_rx_valid = 1'b0, rsp_rx_ready;
  logic [W-1:0] rsp_rx_data = '0;
  logic rsp_tx_valid, rsp_tx_ready = 1'b0;
  logic [W-1:0] rsp_tx_data;
  logic busy, done, timed_out, reply_ok;
  logic [CW-1:0] rtt_count;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtt_probe #(.W(W), .CW(CW), .TIMEOUT(TO)) dut_i (
    .clk, .rst_n, .start, .ping_word,
    .ini_tx_valid, .ini_tx_ready, .ini_tx_data,
    .ini_rx_valid, .ini_rx_ready, .ini_rx_data,
    .rsp_rx_valid, .rsp_rx_ready, .rsp_rx_data,
    .rsp_tx_valid, .rsp_tx_ready, .rsp_tx_data,
    .busy, .done, .timed_out, .reply_ok, .rtt_count
  );

  // reference model: 0 idle, 1 sending, 2 waiting, 3 finished
  int m_ph = 0;
  int m_cnt = 0;
  logic [W-1:0] m_word = '0;
  bit m_to = 0, m_ok = 0;
  logic [W-1:0] m_q[$];

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 ini_tx_valid", ini_tx_valid, m_ph == 1);
    if (m_ph == 1) chk("R3 ini_tx_data", ini_tx_data, m_word);
    chk("R5 ini_rx_ready", ini_rx_ready, m_ph == 2);
    chk("R1 busy", busy, m_ph == 1 || m_ph == 2);
    chk("R1 done", done, m_ph == 3);
    chk("R7 timed_out", timed_out, m_to);
    chk("R6 reply_ok", reply_ok, m_ok);
    chk("R4 R10 rtt_count", rtt_count, m_cnt);
    chk("R8 rsp_tx_valid", rsp_tx_valid, m_q.size() > 0);
    if (m_q.size() > 0) chk("R8 rsp_tx_data", rsp_tx_data, m_q[0]);
    chk("R9 rsp_rx_ready", rsp_rx_ready, m_q.size() == 0 || rsp_tx_ready);
  endtask

  task automatic model_update();
    bit r_acc;
    r_acc = rsp_rx_valid && (m_q.size() == 0 || rsp_tx_ready);
    if (m_q.size() > 0 && rsp_tx_ready) void'(m_q.pop_front());
    if (r_acc) m_q.push_back(rsp_rx_data ^ 32'h1);
    if (m_ph == 0 || m_ph == 3) begin
      if (start) begin
        m_ph = 1; m_word = ping_word; m_cnt = 0; m_to = 0; m_ok = 0;
      end
    end else if (m_ph == 1) begin
      if (ini_tx_ready) m_ph = 2;
    end else begin
      m_cnt++;
      if (ini_rx_valid) begin
        m_ph = 3; m_ok = (ini_rx_data == (m_word ^ 32'h1));
      end else if (m_cnt >= TO) begin
        m_ph = 3; m_to = 1;
      end
    end
  endtask

  task automatic step();
    #1;
    compare();
    model_update();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ping(input logic [W-1:0] w, input int txd, input int rxd,
                      input bit answer, input bit good, input bit poke);
    start = 1'b1; ping_word = w; step(); start = 1'b0;
    repeat (txd) step();
    ini_tx_ready = 1'b1; step(); ini_tx_ready = 1'b0;
    if (answer) begin
      for (int i = 0; i < rxd; i++) begin
        start = poke && (i == 0);
        ping_word = ~w;
        step();
      end
      start = 1'b0;
      ini_rx_valid = 1'b1;
      ini_rx_data = good ? (w ^ 32'h1) : (w ^ 32'h2);
      step();
      ini_rx_valid = 1'b0;
      #1;
      chk("R4 measured delay", rtt_count, rxd + 1);
      chk("R6 match flag", reply_ok, good);
      chk("R5 done after reply", done, 1);
    end else begin
      for (int i = 0; i < TO + 5 && m_ph != 3; i++) step();
      #1;
      chk("R7 timeout count", rtt_count, TO);
      chk("R7 timeout flag", timed_out, 1);
    end
    repeat (3) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #1 compare();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) step();
    ping(32'hA5A5_0010, 2, 5, 1, 1, 0);
    ping(32'h1234_5678, 0, 0, 1, 1, 1);
    ping(32'hDEAD_BEEE, 1, 8, 1, 1, 1);
    ping(32'h0000_0003, 0, 3, 1, 0, 0);
    ping(32'hCAFE_0001, 0, 597, 1, 1, 0);
    ping(32'h0F0F_0F0F, 0, 0, 0, 0, 0);
    ping(32'h7777_0000, 0, TO - 1, 1, 1, 0);
    for (int i = 0; i < 48; i++) begin
      rsp_rx_valid = (i % 3) != 0;
      rsp_rx_data  = 32'h100 + i * 7;
      rsp_tx_ready = (i % 4) != 1 && (i % 7) != 3;
      step();
    end
    rsp_rx_valid = 1'b0; rsp_tx_ready = 1'b1;
    repeat (3) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule